// File: doc/BRIEF.md
# Mode-Triggered SDRAM Command Issuer

This block sits at the front of an SDRAM controller and lets software send single initialisation and maintenance commands to a DDR2 device without a sequencer of its own. Software first stores a command code and, when needed, an address-bus argument and a minimum gap in three small configuration registers. The next host write that falls inside the SDRAM address window is not passed on as data. It is taken as the trigger, and one command chosen by the stored code appears on the SDRAM command pins for exactly one clock cycle.

For load-mode and extended-load-mode commands, the bank bits come from the trigger address. Above the byte, column and row fields of the host address sit the bank bits. With the default geometry (16-bit device, 9 column bits, 12 row bits, 4 banks), these are host address bits 23:22 relative to the window base. After the command, the host is held busy for a programmable number of idle cycles and then receives a one-cycle acknowledge. In normal code, window writes are handed on as data accesses. Writes outside the window issue nothing.

Top module: `mcmd_issuer`

## Requirements
- R1: After reset, `h_ready` is 1, `h_ack` and `data_fwd` are 0, and all four command pins are 1 (deselect), with `sd_ba` and `sd_a` at 0. The stored code is 0 (normal), the argument is 0 and the gap is 2.
- R2: With code 2, an accepted window write drives precharge-all, which is {cs_n,ras_n,cas_n,we_n} = 0010. `sd_a` has only bit 10 set and `sd_ba` is 0.
- R3: With code 3, an accepted window write drives load-mode, {cs_n,ras_n,cas_n,we_n} = 0000. `sd_a` equals the stored argument and `sd_ba` equals the trigger address bank field.
- R4: With code 4, every accepted window write drives one auto-refresh, {cs_n,ras_n,cas_n,we_n} = 0001, with `sd_a` and `sd_ba` at 0. The code stays stored, so two writes give two refreshes.
- R5: With code 5, an accepted window write drives extended load-mode, 0000 on the command pins, with `sd_a` equal to the argument. A write to base+0x400000 gives `sd_ba` = 01.
- R6: The bank field is (address - 0x20000000) / 0x400000 modulo 4. The base gives 00 and base+0xC00000 gives 11.
- R7: With any code other than 2 to 5, an accepted window write issues no command. Instead, `data_fwd` and `h_ack` are both high for one cycle, in the cycle after acceptance.
- R8: A write outside 0x20000000 to 0x2FFFFFFF issues no command and no `data_fwd`. It is acknowledged in the cycle after acceptance.
- R9: A command is driven for exactly one cycle, in the cycle after acceptance, and is followed by deselect.
- R10: `h_ack` is high for one cycle, gap+1 cycles after the command cycle. `h_ready` is 0 from the command cycle through the acknowledge cycle, and is 1 in the cycle after it.
- R11: A write is accepted only on a clock edge where `h_req` and `h_ready` are both 1. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 code, 1 address argument, 2 gap |
| cfg_wdata | input | 13 | Configuration write data |
| h_req | input | 1 | Host write request |
| h_addr | input | 32 | Host write byte address |
| h_ready | output | 1 | Block idle, request will be taken |
| h_ack | output | 1 | One-cycle completion pulse |
| data_fwd | output | 1 | Window write passed on as data |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_a | output | 13 | SDRAM address bus |

## Verification
The assertions assume the host raises `h_req` only as a single-cycle pulse, or holds it while `h_ready` is low. They also assume the configuration registers are not rewritten while a command is in flight. The bench meets both assumptions: it writes configuration only while the block is idle, and it drives each request for one cycle from the falling edge once `h_ready` is seen. The one exception is the busy-request test, which deliberately holds `h_req` during the command cycle.

// File: rtl/mci_pkg.sv
`timescale 1ns/1ps
package mci_pkg;

  typedef enum logic [2:0] {
    MC_NORMAL = 3'd0,
    MC_SPARE1 = 3'd1,
    MC_PREALL = 3'd2,
    MC_LMR    = 3'd3,
    MC_REF    = 3'd4,
    MC_EXTLMR = 3'd5,
    MC_SPARE6 = 3'd6,
    MC_SPARE7 = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_FWD  = 2'd1,
    ACT_CMD  = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_ACK   = 2'd3
  } seq_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_DESEL  = 4'b1111;
  localparam pins_t PINS_PREALL = 4'b0010;
  localparam pins_t PINS_REF    = 4'b0001;
  localparam pins_t PINS_LMR    = 4'b0000;

  localparam logic [1:0] CSEL_MODE = 2'd0;
  localparam logic [1:0] CSEL_ARG  = 2'd1;
  localparam logic [1:0] CSEL_GAP  = 2'd2;

endpackage

// File: rtl/mci_regs.sv
`timescale 1ns/1ps
module mci_regs
  import mci_pkg::*;
#(
  parameter int SA_W    = 13,
  parameter int GAP_W   = 8,
  parameter int GAP_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [SA_W-1:0]  cfg_wdata,
  output mode_e            mode_q,
  output logic [SA_W-1:0]  arg_q,
  output logic [GAP_W-1:0] gap_q
);

  localparam int MODE_W = $bits(mode_e);

  logic wr_mode, wr_arg, wr_gap;

  assign wr_mode = cfg_we && (cfg_sel == CSEL_MODE);
  assign wr_arg  = cfg_we && (cfg_sel == CSEL_ARG);
  assign wr_gap  = cfg_we && (cfg_sel == CSEL_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MC_NORMAL;
    end else if (wr_mode) begin
      mode_q <= mode_e'(cfg_wdata[MODE_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0;
    end else if (wr_arg) begin
      arg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_W'(GAP_RST);
    end else if (wr_gap) begin
      gap_q <= cfg_wdata[GAP_W-1:0];
    end
  end

endmodule

// File: rtl/mci_decode.sv
`timescale 1ns/1ps
module mci_decode
  import mci_pkg::*;
#(
  parameter int              HA_W      = 32,
  parameter logic [HA_W-1:0] BASE      = 32'h2000_0000,
  parameter int              WIN_BITS  = 28,
  parameter int              BYTE_BITS = 1,
  parameter int              COL_BITS  = 9,
  parameter int              ROW_BITS  = 12,
  parameter int              BA_W      = 2,
  parameter int              SA_W      = 13,
  parameter int              A10_BIT   = 10
) (
  input  logic [HA_W-1:0] h_addr,
  input  mode_e           mode,
  input  logic [SA_W-1:0] arg,
  output logic            in_win,
  output act_e            act,
  output pins_t           pins,
  output logic [BA_W-1:0] ba,
  output logic [SA_W-1:0] sa
);

  localparam int              BA_LSB  = BYTE_BITS + COL_BITS + ROW_BITS;
  localparam logic [HA_W:0]   WIN_END = {1'b0, BASE} + ((HA_W+1)'(1) << WIN_BITS);
  localparam logic [SA_W-1:0] SA_PRE  = SA_W'(1) << A10_BIT;

  function automatic logic f_in_window(input logic [HA_W-1:0] a);
    return (a >= BASE) && ({1'b0, a} < WIN_END);
  endfunction

  function automatic logic [BA_W-1:0] f_bank(input logic [HA_W-1:0] a);
    return BA_W'((a - BASE) >> BA_LSB);
  endfunction

  function automatic logic f_is_cmd(input mode_e m);
    return (m == MC_PREALL) || (m == MC_LMR) || (m == MC_REF) || (m == MC_EXTLMR);
  endfunction

  assign in_win = f_in_window(h_addr);

  always_comb begin
    if (!in_win)             act = ACT_NONE;
    else if (f_is_cmd(mode)) act = ACT_CMD;
    else                     act = ACT_FWD;
  end

  always_comb begin
    pins = PINS_DESEL;
    ba   = '0;
    sa   = '0;
    unique case (mode)
      MC_PREALL: begin
        pins = PINS_PREALL;
        sa   = SA_PRE;
      end
      MC_REF: begin
        pins = PINS_REF;
      end
      MC_LMR, MC_EXTLMR: begin
        pins = PINS_LMR;
        ba   = f_bank(h_addr);
        sa   = arg;
      end
      default: begin
        pins = PINS_DESEL;
      end
    endcase
  end

endmodule

// File: rtl/mci_seq.sv
`timescale 1ns/1ps
module mci_seq
  import mci_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int SA_W  = 13,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_req,
  input  act_e             act,
  input  pins_t            pins,
  input  logic [BA_W-1:0]  ba,
  input  logic [SA_W-1:0]  sa,
  input  logic [GAP_W-1:0] gap,
  output logic             accept_evt,
  output logic             h_ready,
  output logic             h_ack,
  output logic             data_fwd,
  output pins_t            pins_q,
  output logic [BA_W-1:0]  ba_q,
  output logic [SA_W-1:0]  sa_q
);

  seq_e             state;
  logic [GAP_W-1:0] cnt;
  logic             take_cmd;

  assign h_ready    = (state == S_IDLE);
  assign h_ack      = (state == S_ACK);
  assign accept_evt = h_req && h_ready;
  assign take_cmd   = accept_evt && (act == ACT_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept_evt) state <= take_cmd ? S_ISSUE : S_ACK;
        end
        S_ISSUE: begin
          if (gap == '0) begin
            state <= S_ACK;
          end else begin
            state <= S_WAIT;
            cnt   <= gap;
          end
        end
        S_WAIT: begin
          if (cnt == GAP_W'(1)) state <= S_ACK;
          cnt <= cnt - GAP_W'(1);
        end
        S_ACK: begin
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= PINS_DESEL;
      ba_q     <= '0;
      sa_q     <= '0;
      data_fwd <= 1'b0;
    end else begin
      pins_q   <= take_cmd ? pins : PINS_DESEL;
      ba_q     <= take_cmd ? ba   : '0;
      sa_q     <= take_cmd ? sa   : '0;
      data_fwd <= accept_evt && (act == ACT_FWD);
    end
  end

endmodule

// File: rtl/mcmd_issuer.sv
`timescale 1ns/1ps
module mcmd_issuer
  import mci_pkg::*;
#(
  parameter int              HA_W      = 32,
  parameter logic [HA_W-1:0] BASE      = 32'h2000_0000,
  parameter int              WIN_BITS  = 28,
  parameter int              BYTE_BITS = 1,
  parameter int              COL_BITS  = 9,
  parameter int              ROW_BITS  = 12,
  parameter int              BA_W      = 2,
  parameter int              SA_W      = 13,
  parameter int              A10_BIT   = 10,
  parameter int              GAP_W     = 8,
  parameter int              GAP_RST   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [SA_W-1:0] cfg_wdata,
  input  logic            h_req,
  input  logic [HA_W-1:0] h_addr,
  output logic            h_ready,
  output logic            h_ack,
  output logic            data_fwd,
  output logic            sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [BA_W-1:0] sd_ba,
  output logic [SA_W-1:0] sd_a
);

  mode_e            mode_q;
  logic [SA_W-1:0]  arg_q;
  logic [GAP_W-1:0] gap_q;
  logic             in_win;
  act_e             act;
  pins_t            pins_d, pins_q;
  logic [BA_W-1:0]  ba_d;
  logic [SA_W-1:0]  sa_d;
  logic             accept_evt;

  mci_regs #(.SA_W(SA_W), .GAP_W(GAP_W), .GAP_RST(GAP_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mode_q    (mode_q),
    .arg_q     (arg_q),
    .gap_q     (gap_q)
  );

  mci_decode #(
    .HA_W(HA_W), .BASE(BASE), .WIN_BITS(WIN_BITS), .BYTE_BITS(BYTE_BITS),
    .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS), .BA_W(BA_W), .SA_W(SA_W),
    .A10_BIT(A10_BIT)
  ) u_dec (
    .h_addr (h_addr),
    .mode   (mode_q),
    .arg    (arg_q),
    .in_win (in_win),
    .act    (act),
    .pins   (pins_d),
    .ba     (ba_d),
    .sa     (sa_d)
  );

  mci_seq #(.BA_W(BA_W), .SA_W(SA_W), .GAP_W(GAP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_req      (h_req),
    .act        (act),
    .pins       (pins_d),
    .ba         (ba_d),
    .sa         (sa_d),
    .gap        (gap_q),
    .accept_evt (accept_evt),
    .h_ready    (h_ready),
    .h_ack      (h_ack),
    .data_fwd   (data_fwd),
    .pins_q     (pins_q),
    .ba_q       (sd_ba),
    .sa_q       (sd_a)
  );

  assign sd_cs_n  = pins_q.cs_n;
  assign sd_ras_n = pins_q.ras_n;
  assign sd_cas_n = pins_q.cas_n;
  assign sd_we_n  = pins_q.we_n;

endmodule

// File: rtl/mcmd_issuer_chk.sv
`timescale 1ns/1ps
module mcmd_issuer_chk #(
  parameter int BA_W    = 2,
  parameter int SA_W    = 13,
  parameter int A10_BIT = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            h_ready,
  input logic            h_ack,
  input logic            data_fwd,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic [SA_W-1:0] sa,
  input logic            accept_evt,
  input logic            in_win
);

  logic is_pre, is_ref;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;

  p_pre_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sa[A10_BIT] && ba == '0));

  p_ref_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (sa == '0 && ba == '0));

  p_fwd_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_fwd |-> (h_ack && cs_n));

  p_only_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || data_fwd) |-> $past(in_win));

  p_cmd_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);

  p_busy_in_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !h_ready);

  p_ack_then_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> (!h_ack && h_ready));

  p_cmd_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || data_fwd) |-> $past(accept_evt));

endmodule

bind mcmd_issuer mcmd_issuer_chk #(.BA_W(BA_W), .SA_W(SA_W), .A10_BIT(A10_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h_ready    (h_ready),
  .h_ack      (h_ack),
  .data_fwd   (data_fwd),
  .cs_n       (sd_cs_n),
  .ras_n      (sd_ras_n),
  .cas_n      (sd_cas_n),
  .we_n       (sd_we_n),
  .ba         (sd_ba),
  .sa         (sd_a),
  .accept_evt (accept_evt),
  .in_win     (in_win)
);

// File: tb/sim_mcmd_issuer.sv
`timescale 1ns/1ps
module sim_mcmd_issuer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [12:0] cfg_wdata = '0;
  logic        h_req = 1'b0;
  logic [31:0] h_addr = '0;
  logic        h_ready, h_ack, data_fwd;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;

  always #2.5 clk = ~clk;

  mcmd_issuer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .h_req(h_req), .h_addr(h_addr),
    .h_ready(h_ready), .h_ack(h_ack), .data_fwd(data_fwd),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [19:0] exp_q[$];
  string       tag_q[$];

  int unsigned cur_mode = 0;
  int unsigned cur_arg  = 0;
  int unsigned cur_gap  = 2;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_in_win(input logic [31:0] a);
    return (a >= 32'h2000_0000) && (a <= 32'h2FFF_FFFF);
  endfunction

  function automatic logic [1:0] exp_bank(input logic [31:0] a);
    return 2'(((a - 32'h2000_0000) / 32'h40_0000) % 4);
  endfunction

  // packed item: {cs,ras,cas,we, ba[1:0], sa[12:0], fwd}
  function automatic logic [19:0] exp_item(input logic [31:0] a);
    case (cur_mode)
      2: return {4'b0010, 2'b00, 13'h0400, 1'b0};
      3, 5: return {4'b0000, exp_bank(a), 13'(cur_arg), 1'b0};
      4: return {4'b0001, 2'b00, 13'h0000, 1'b0};
      default: return {4'b1111, 2'b00, 13'h0000, 1'b1};
    endcase
  endfunction

  // scoreboard monitor
  bit prev_cmd = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_cmd) check(sd_cs_n, "R9", "deselect after command", sd_cs_n, 1);
      if (!sd_cs_n || data_fwd) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 R11", "unexpected command",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
        end else begin
          logic [19:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a, data_fwd} == e,
                t, "command pins/ba/a/fwd",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a, data_fwd}, e);
        end
      end
      prev_cmd = !sd_cs_n;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input int unsigned val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 13'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: cur_mode = val % 8;
      2'd1: cur_arg  = val;
      2'd2: cur_gap  = val % 256;
      default: ;
    endcase
  endtask

  task automatic host_write(input logic [31:0] a, input string tag, input bit poke);
    int lat;
    int exp_lat;
    bit is_cmd;
    is_cmd = exp_in_win(a) && (cur_mode >= 2) && (cur_mode <= 5);
    exp_lat = is_cmd ? int'(cur_gap) + 1 : 0;
    if (exp_in_win(a)) begin
      exp_q.push_back(exp_item(a));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_req = 1'b1; h_addr = a;
    @(negedge clk);
    h_req = poke;
    lat = 0;
    while (!h_ack && lat < 300) begin
      if (poke && lat == 0) check(!h_ready, "R11", "busy during poke", h_ready, 0);
      @(negedge clk);
      h_req = 1'b0;
      lat++;
    end
    h_req = 1'b0;
    check(lat == exp_lat, is_cmd ? "R10" : (exp_in_win(a) ? "R7" : "R8"),
          "ack latency", lat, exp_lat);
    @(negedge clk);
    check(h_ready && !h_ack, "R10", "ready after ack", {h_ready, h_ack}, 2'b10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(h_ready && !h_ack && !data_fwd, "R1", "handshake at reset",
          {h_ready, h_ack, data_fwd}, 3'b100);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a} == {4'hF, 2'b0, 13'h0},
          "R1", "pins at reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a},
          {4'hF, 2'b0, 13'h0});
    // R1: normal code at reset, default gap irrelevant for forwarding
    host_write(32'h2000_0010, "R1 R7", 1'b0);

    // R2 precharge all, gap 3
    cfg_write(2'd2, 3);
    cfg_write(2'd0, 2);
    host_write(32'h2000_1234, "R2", 1'b0);

    // R3 load mode at base, R6 bank 00
    cfg_write(2'd1, 13'h0532);
    cfg_write(2'd0, 3);
    host_write(32'h2000_0000, "R3 R6", 1'b0);
    host_write(32'h2080_0000, "R3 R6", 1'b0);

    // R5 extended load mode, bank from address
    cfg_write(2'd1, 13'h0044);
    cfg_write(2'd0, 5);
    host_write(32'h2040_0000, "R5", 1'b0);
    host_write(32'h20C0_0000, "R5 R6", 1'b0);

    // R4 two refreshes, gap 0 boundary
    cfg_write(2'd2, 0);
    cfg_write(2'd0, 4);
    host_write(32'h2123_4560, "R4", 1'b0);
    host_write(32'h2FFF_FFFE, "R4", 1'b0);

    // R8 outside window
    host_write(32'h1FFF_FFFE, "R8", 1'b0);
    host_write(32'h3000_0000, "R8", 1'b0);

    // R11 request while busy ignored
    cfg_write(2'd2, 5);
    host_write(32'h2000_0100, "R11 R4", 1'b1);

    // R7 forward in normal and spare codes
    cfg_write(2'd0, 0);
    host_write(32'h2000_0008, "R7", 1'b0);
    cfg_write(2'd0, 6);
    host_write(32'h2555_0000, "R7", 1'b0);
    cfg_write(2'd0, 1);
    host_write(32'h2000_0002, "R7", 1'b0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "all expected commands seen", exp_q.size(), 0);
    finish_run();
  end

endmodule